// File: doc/BRIEF.md
# VGA Multi-Byte Access Sequencer

This block sits at the head of a graphics pipeline. It takes single bus accesses to VGA memory that are 8, 16 or 32 bits wide and turns each one into a series of one-byte operations on a byte-wide port. The read and write paths and the memory behind that port are separate blocks. For a write, every step carries one byte of the bus data and its own byte address. For a read, every step fetches one byte, and the sequencer packs the bytes it receives into the word it returns on the bus.

The sequencer generates the low address bits of each byte operation itself. It starts from the low bits of the request address and adds one for each further byte. Bytes go out least significant first. The bus request is held not-ready until the last byte operation has been accepted. It then completes in a single cycle, and for a read the assembled word is returned in that same cycle.

Top module: `vga_byte_sequencer`

## Requirements
- R1: A request with size code 0 produces exactly one byte operation, code 1 produces two, and codes 2 and 3 produce four. For a write request every one of these has `byteWrite` high.
- R2: For a write, byte operation k (counting from 0) carries bits [8k+7:8k] of `reqWdata` on `byteWdata`.
- R3: On byte operation k, `byteAddr` keeps the request address above bit 1. Its low two bits are (`reqAddr[1:0]` + k) mod 4, so they wrap inside the aligned 4-byte group.
- R4: For a read, every byte operation has `byteWrite` low. The `byteRdata` value present in the cycle that byte k is accepted is returned in `rspRdata[8k+7:8k]`. Bytes at and above the requested size read as zero.
- R5: `reqReady` is high for exactly one cycle per request. That cycle comes only after the last byte operation has been accepted, and `byteValid` is never high in it.
- R6: `rspValid` is high in the completion cycle of a read and is low in the completion cycle of a write.
- R7: While `byteValid` is high and `byteReady` is low, `byteValid`, `byteAddr`, `byteWdata` and `byteWrite` stay unchanged into the next cycle.
- R8: During and right after reset, `reqReady`, `rspValid` and `byteValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request present. It is held, together with its fields, until `reqReady` |
| reqReady | output | 1 | Single-cycle completion of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit |
| reqWdata | input | DATA_W | Write data, least significant byte first |
| rspValid | output | 1 | Read data valid. It is high only together with `reqReady` |
| rspRdata | output | DATA_W | Assembled read word |
| byteValid | output | 1 | Byte operation present |
| byteReady | input | 1 | Byte operation accepted in this cycle |
| byteWrite | output | 1 | Direction of the byte operation |
| byteAddr | output | ADDR_W | Address of the byte operation, including the generated low bits |
| byteWdata | output | 8 | Byte to be written |
| byteRdata | input | 8 | Byte read back, taken in the cycle it is accepted |

## Verification
The bench sweeps every size code with every starting offset within the 4-byte group, in both directions, and repeats the sweep under three acceptance patterns on the byte port: always ready, alternating, and pseudo-random stalls. The offsets 1 to 3 with 16-bit and 32-bit sizes separate a correct wrap of the low address bits from a carry into the upper address. Distinct write bytes and address-dependent read bytes expose any swap of lane order. The stall patterns separate a design that holds its byte operation steady from one that advances or loses a byte while waiting.

// File: rtl/vga_seq_pkg.sv
package vga_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // current byte accepted, move to the next
  } seqStrobe_t;

endpackage

// File: rtl/vga_seq_datapath.sv
module vga_seq_datapath
  import vga_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [7:0]        byteRdata,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [7:0]        byteWdata,
  output logic              byteWrite,
  output logic [DATA_W-1:0] rdataAcc,
  output logic              lastByte
);

  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;

  logic [ADDR_W-1:LANE_W] addrHi;
  logic [LANE_W-1:0]      lowBits;
  logic [LANE_W-1:0]      stepIdx;
  logic [LANE_W-1:0]      stepLimit;
  logic [DATA_W-1:0]      wdataShift;
  logic                   isWrite;

  // index of the last byte for a given size code, clamped to the bus width
  function automatic logic [LANE_W-1:0] lastIdx(input logic [1:0] sz);
    int unsigned cnt;
    cnt = 32'd1 << sz;
    if (cnt > NB) cnt = NB;
    return LANE_W'(cnt - 1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi     <= '0;
      lowBits    <= '0;
      stepIdx    <= '0;
      stepLimit  <= '0;
      wdataShift <= '0;
      isWrite    <= 1'b0;
    end else if (strobe.load) begin
      addrHi     <= reqAddr[ADDR_W-1:LANE_W];
      lowBits    <= reqAddr[LANE_W-1:0];
      stepIdx    <= '0;
      stepLimit  <= lastIdx(reqSize);
      wdataShift <= reqWdata;
      isWrite    <= reqWrite;
    end else if (strobe.step) begin
      lowBits    <= lowBits + 1'b1;
      stepIdx    <= stepIdx + 1'b1;
      wdataShift <= {8'h00, wdataShift[DATA_W-1:8]};
    end
  end

  // one capture register per byte lane of the read word
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneQ <= '0;
      else if (strobe.load)
        laneQ <= '0;
      else if (strobe.step && !isWrite && (stepIdx == LANE_W'(g)))
        laneQ <= byteRdata;
    end
    assign rdataAcc[8*g +: 8] = laneQ;
  end

  assign byteAddr  = {addrHi, lowBits};
  assign byteWdata = wdataShift[7:0];
  assign byteWrite = isWrite;
  assign lastByte  = (stepIdx == stepLimit);

endmodule

// File: rtl/vga_seq_control.sv
module vga_seq_control
  import vga_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       byteReady,
  input  logic       lastByte,
  input  logic       isWrite,
  output seqStrobe_t strobe,
  output logic       byteValid,
  output logic       reqReady,
  output logic       rspValid
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    byteValid   = 1'b0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = ST_BUSY;
        end
      end
      ST_BUSY: begin
        byteValid = 1'b1;
        if (byteReady) begin
          strobe.step = 1'b1;
          if (lastByte) stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        reqReady = 1'b1;
        rspValid = !isWrite;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vga_byte_sequencer.sv
module vga_byte_sequencer
  import vga_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              byteValid,
  input  logic              byteReady,
  output logic              byteWrite,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [7:0]        byteWdata,
  input  logic [7:0]        byteRdata
);

  seqStrobe_t strobe;
  logic       lastByte;

  vga_seq_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .byteReady (byteReady),
    .lastByte  (lastByte),
    .isWrite   (byteWrite),
    .strobe    (strobe),
    .byteValid (byteValid),
    .reqReady  (reqReady),
    .rspValid  (rspValid)
  );

  vga_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .byteRdata (byteRdata),
    .byteAddr  (byteAddr),
    .byteWdata (byteWdata),
    .byteWrite (byteWrite),
    .rdataAcc  (rspRdata),
    .lastByte  (lastByte)
  );

endmodule

// File: rtl/vga_seq_checker.sv
module vga_seq_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              byteValid,
  input logic              byteReady,
  input logic              byteWrite,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [7:0]        byteWdata
);

  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteAddr) && $stable(byteWdata) && $stable(byteWrite)); // R7

  AST_DONE_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !byteValid); // R5

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R5

  AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady && !byteWrite); // R6

  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && byteWrite |-> !rspValid); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && byteValid && $past(byteValid && byteReady) |->
      (byteAddr[LANE_W-1:0] == LANE_W'($past(byteAddr[LANE_W-1:0]) + 1'b1)) &&
      (byteAddr[ADDR_W-1:LANE_W] == $past(byteAddr[ADDR_W-1:LANE_W]))); // R3

endmodule

bind vga_byte_sequencer vga_seq_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .byteValid (byteValid),
  .byteReady (byteReady),
  .byteWrite (byteWrite),
  .byteAddr  (byteAddr),
  .byteWdata (byteWdata)
);

// File: tb/test_vga_byte_sequencer.sv
module test_vga_byte_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspRdata;
  logic              byteValid;
  logic              byteReady = 1'b0;
  logic              byteWrite;
  logic [ADDR_W-1:0] byteAddr;
  logic [7:0]        byteWdata;
  logic [7:0]        byteRdata;

  int checks = 0;
  int errors = 0;
  int stallMode = 0;
  int tick = 0;

  logic [ADDR_W-1:0] logAddr [8];
  logic [7:0]        logData [8];
  logic              logWr   [8];
  int                logCnt = 0;

  logic              prevValid = 1'b0, prevReady = 1'b0, prevWr = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic [7:0]        prevData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_byte_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_vga_byte_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .byteValid(byteValid),
    .byteReady(byteReady), .byteWrite(byteWrite), .byteAddr(byteAddr),
    .byteWdata(byteWdata), .byteRdata(byteRdata)
  );

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7 + 8'h3C) ^ a[15:8];
  endfunction

  assign byteRdata = memByte(byteAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // byte-port responder: decides acceptance, logs accepted bytes, checks stalls
  always @(negedge clk) begin
    logic rdy;
    tick++;
    if (!rstN) begin
      byteReady = 1'b0;
      prevValid = 1'b0;
    end else begin
      if (prevValid && !prevReady) begin
        chk(byteValid && byteAddr == prevAddr && byteWdata == prevData && byteWrite == prevWr,
            "R7", "stalled byte changed", {byteValid, 3'b0, byteAddr[19:0], byteWdata},
            {1'b1, 3'b0, prevAddr[19:0], prevData});
      end
      case (stallMode)
        0: rdy = 1'b1;
        1: rdy = tick[0];
        default: rdy = ($urandom % 3) != 0;
      endcase
      byteReady = rdy;
      if (byteValid && rdy && logCnt < 8) begin
        logAddr[logCnt] = byteAddr;
        logData[logCnt] = byteWdata;
        logWr[logCnt]   = byteWrite;
        logCnt++;
      end
      prevValid = byteValid;
      prevReady = rdy;
      prevAddr  = byteAddr;
      prevData  = byteWdata;
      prevWr    = byteWrite;
    end
  end

  task automatic doReq(input bit w, input logic [1:0] sz,
                       input logic [ADDR_W-1:0] a, input logic [31:0] wd);
    int n;
    int cyc;
    logic [31:0] expR;
    logic [1:0] lo;
    logic gotRsp;
    logic [31:0] gotData;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    @(negedge clk);
    logCnt   = 0;
    reqValid = 1'b1;
    reqWrite = w;
    reqSize  = sz;
    reqAddr  = a;
    reqWdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (reqReady && byteValid)
        chk(1'b0, "R5", "byteValid during completion", 32'd1, 32'd0);
    end while (!reqReady && cyc < 300);
    chk(reqReady, "R5", "request never completed", {31'd0, reqReady}, 32'd1);
    gotRsp  = rspValid;
    gotData = rspRdata;
    chk(logCnt == n, "R1", "byte operation count", logCnt, n);
    chk(gotRsp == !w, "R6", "rspValid at completion", {31'd0, gotRsp}, {31'd0, !w});
    expR = '0;
    for (int k = 0; k < n && k < logCnt; k++) begin
      lo = a[1:0] + 2'(k);
      chk(logAddr[k] == {a[ADDR_W-1:2], lo}, "R3", "byte address",
          {12'd0, logAddr[k]}, {12'd0, a[ADDR_W-1:2], lo});
      chk(logWr[k] == w, w ? "R1" : "R4", "byte direction", {31'd0, logWr[k]}, {31'd0, w});
      if (w)
        chk(logData[k] == wd[8*k +: 8], "R2", "write byte", {24'd0, logData[k]},
            {24'd0, wd[8*k +: 8]});
      expR[8*k +: 8] = memByte({a[ADDR_W-1:2], lo});
    end
    if (!w) chk(gotData == expR, "R4", "assembled read word", gotData, expR);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R5", "reqReady longer than one cycle", {31'd0, reqReady}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!reqReady && !rspValid && !byteValid, "R8", "outputs in reset",
        {29'd0, reqReady, rspValid, byteValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqReady && !rspValid && !byteValid, "R8", "outputs after reset",
        {29'd0, reqReady, rspValid, byteValid}, 32'd0);
    for (int m = 0; m < 3; m++) begin
      stallMode = m;
      for (int s = 0; s < 4; s++)
        for (int off = 0; off < 4; off++)
          for (int d = 0; d < 2; d++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] wd;
            a  = ADDR_W'(20'hA0000 + (m*16 + s*4 + off)*20'h124 + off);
            a[1:0] = 2'(off);
            wd = 32'h8C4D2E1F ^ (32'h01030507 * (m*32 + s*8 + off*2 + d + 1));
            doReq(d == 0, 2'(s), a, wd);
          end
    end
    // upper address carry must not happen on wrap
    stallMode = 2;
    doReq(1'b0, 2'd2, 20'hBFFFF, 32'd0);
    doReq(1'b1, 2'd1, 20'hAFFFF, 32'hDEADBEEF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule